// File: doc/BRIEF.md
# Interrupt Redirection and Message Delivery Engine

This block sits between a bank of interrupt input lines and a message-signalled interrupt bus. Each input pin has a redirection entry and a pending bit. The entry holds the vector, the delivery mode, the destination, the destination mode, the trigger kind and a mask. The engine watches the pins, decides which requests are due, and sends each due request as one 32-bit address / 32-bit data write on an outgoing valid/ready port. A register block shares the entries through a simple word-wide table port. A separate input accepts end-of-interrupt notices that carry a vector.

Edge pins latch a request on a rising input and release it when it is sent. A rising input on a masked edge pin is discarded. Level pins track the input. When a level request is sent, the entry's acknowledge-lockout bit is set. From then on the pin sends nothing more until an end-of-interrupt with the same vector clears that bit. If the pin is still asserted and unmasked at that point, it is delivered again. Input line 0 is folded onto pin 2, and pin 0 never requests. When several pins are due at once, the lowest pin index goes first. The scan stays on a launched message until the bus accepts it.

Top module: `irq_route_engine`

## Requirements
- R1: When several pins are eligible, the lowest-indexed one is launched first. Eligible means pending, unmasked, and not a level pin with its lockout set. The others follow in ascending index order, one per accepted message.
- R2: A rising input on an unmasked edge pin (trigger bit 0) sets its pending bit. Launching its message clears that bit, so each edge yields exactly one message.
- R3: Launching a level pin (trigger bit 1) sets its lockout bit (low-word bit 14). While that bit is set, the pin launches no further message even though its input stays high.
- R4: A rising input on an edge pin whose mask bit (low-word bit 16) is 1 is discarded. Clearing the mask afterwards produces no message.
- R5: On a level pin the pending bit follows the input. A masked level pin keeps its request without delivering it, and sends it once the mask is cleared. Deasserting the input withdraws the request.
- R6: Input line 0 drives pin 2, OR-ed with input line 2. Pin 0 never becomes pending.
- R7: While msg_valid is high and msg_ready is low, msg_valid stays high and msg_addr and msg_data do not change.
- R8: An end-of-interrupt clears the lockout bit of every entry whose lockout is set and whose vector equals eoi_vector. A matched pin that is still pending and unmasked is then delivered again. A notice with any other vector changes nothing.
- R9: The message address is 0xFEE00000 OR (destination << 12) OR (destination mode << 2). The message data is vector OR (delivery mode << 8) OR (trigger << 15).
- R10: Entry layout. The low word (tbl_half=0) holds vector [7:0], delivery mode [10:8], destination mode [11], lockout [14] (read-only), trigger [15] and mask [16]. All other low-word bits read 0. The high word (tbl_half=1) holds the destination in [31:16], and [15:0] read 0. A table index of NPINS or more reads 0 and ignores writes.
- R11: An entry whose trigger bit becomes 0 has its lockout bit cleared.
- R12: After reset every entry reads 0x00010000 in the low word (masked, edge) and 0 in the high word, and no message is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Interrupt input lines, synchronous to clk |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | clog2(NPINS) | Table entry index |
| tbl_half | input | 1 | Table word select: 0 low word, 1 high word |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data (combinational from index and half) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Outgoing message accepted |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench sweeps edge delivery over every pin from 1 to 23, each with its own vector, delivery mode, destination and destination mode. Each message is compared with an address and data computed arithmetically, and the bench confirms no second message follows. A wrong encoding would give a wrong word, and a pending bit that was not released would give a duplicate. The bench also targets these cases:
- Stalled-bus ordering. Three pins fire together; a picker that was not lowest-first, or that changed the message while stalled, would emit out of order or corrupt the held word.
- Level lockout and vector-matched end-of-interrupt. A design that ignored the lockout would flood messages, and one that matched any vector would redeliver early.
- Masked-edge discard, masked-level retention, edge-switch lockout clear, and the line-0 fold. Each would show up as a missing or spurious message or a wrong readback bit.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;
  localparam int DEST_SHIFT  = 12;
  localparam int DMODE_SHIFT = 2;
  localparam int DLV_SHIFT   = 8;
  localparam int TRIG_SHIFT  = 15;

  typedef struct packed {
    logic [15:0] dest;
    logic        mask;
    logic        trig;   // 1 = level
    logic        rem;    // acknowledge lockout
    logic        dmode;
    logic [2:0]  dlv;
    logic [7:0]  vec;
  } rte_t;

  localparam rte_t RTE_RESET = '{dest: 16'h0, mask: 1'b1, trig: 1'b0,
                                 rem: 1'b0, dmode: 1'b0, dlv: 3'h0, vec: 8'h0};

  function automatic logic [31:0] rte_lo(input rte_t e);
    return {15'h0, e.mask, e.trig, e.rem, 2'b00, e.dmode, e.dlv, e.vec};
  endfunction

  function automatic logic [31:0] rte_hi(input rte_t e);
    return {e.dest, 16'h0};
  endfunction

  function automatic rte_t rte_put_lo(input rte_t e, input logic [31:0] w);
    rte_t r;
    r       = e;
    r.vec   = w[7:0];
    r.dlv   = w[10:8];
    r.dmode = w[11];
    r.trig  = w[15];
    r.mask  = w[16];
    return r;
  endfunction

  function automatic rte_t rte_put_hi(input rte_t e, input logic [31:0] w);
    rte_t r;
    r      = e;
    r.dest = w[31:16];
    return r;
  endfunction

  function automatic logic [31:0] msg_addr_of(input rte_t e);
    return MSG_BASE | (32'(e.dest) << DEST_SHIFT) | (32'(e.dmode) << DMODE_SHIFT);
  endfunction

  function automatic logic [31:0] msg_data_of(input rte_t e);
    return 32'(e.vec) | (32'(e.dlv) << DLV_SHIFT) | (32'(e.trig) << TRIG_SHIFT);
  endfunction

endpackage

// File: rtl/irq_pin_front.sv
module irq_pin_front #(
  parameter int NPINS = 24,
  parameter int SRC   = 0,
  parameter int DST   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] rise
);
  logic [NPINS-1:0] lvl_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_map
    if (i == SRC) begin : g_src
      assign lvl[i] = 1'b0;
    end else if (i == DST) begin : g_dst
      assign lvl[i] = pin_in[i] | pin_in[SRC];
    end else begin : g_pass
      assign lvl[i] = pin_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N    = 24,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     elig,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
  end
  assign any = |elig;
endmodule

// File: rtl/irq_msg_port.sv
module irq_msg_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] addr_in,
  input  logic [31:0] data_in,
  input  logic        ready,
  output logic        valid,
  output logic [31:0] addr,
  output logic [31:0] data,
  output logic        free
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= addr_in;
      data  <= data_in;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
  assign free = !valid || ready;
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NPINS     = 24,
  parameter int REMAP_SRC = 0,
  parameter int REMAP_DST = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         pin_in,
  input  logic                     tbl_we,
  input  logic [$clog2(NPINS)-1:0] tbl_idx,
  input  logic                     tbl_half,
  input  logic [31:0]              tbl_wdata,
  output logic [31:0]              tbl_rdata,
  input  logic                     eoi_valid,
  input  logic [7:0]               eoi_vector,
  output logic                     msg_valid,
  input  logic                     msg_ready,
  output logic [31:0]              msg_addr,
  output logic [31:0]              msg_data
);
  localparam int IDX_W = $clog2(NPINS);

  logic [NPINS-1:0] lvl, rise;
  logic [NPINS-1:0] elig, pend_vec, mask_vec, trig_vec, rem_vec;
  logic             pick_any, port_free, launch;
  logic [IDX_W-1:0] launch_idx;
  rte_t             ent_arr [NPINS];

  irq_pin_front #(.NPINS(NPINS), .SRC(REMAP_SRC), .DST(REMAP_DST)) u_front (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lvl(lvl), .rise(rise));

  irq_prio_pick #(.N(NPINS), .IDX_W(IDX_W)) u_pick (
    .elig(elig), .any(pick_any), .idx(launch_idx));

  assign launch = pick_any && port_free;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    rte_t ent_q, ent_d;
    logic pend_q, pend_d;
    logic sel_wr, hit_eoi, hit_launch;

    assign sel_wr     = tbl_we && (tbl_idx == IDX_W'(g));
    assign hit_eoi    = eoi_valid && ent_q.rem && (ent_q.vec == eoi_vector);
    assign hit_launch = launch && (launch_idx == IDX_W'(g));

    always_comb begin
      ent_d = ent_q;
      if (sel_wr) ent_d = tbl_half ? rte_put_hi(ent_q, tbl_wdata) : rte_put_lo(ent_q, tbl_wdata);
      if (hit_eoi) ent_d.rem = 1'b0;
      if (hit_launch && ent_q.trig) ent_d.rem = 1'b1;
      if (!ent_d.trig) ent_d.rem = 1'b0;
      if (ent_q.trig) begin
        pend_d = lvl[g];
      end else begin
        pend_d = pend_q;
        if (hit_launch) pend_d = 1'b0;
        if (rise[g] && !ent_q.mask) pend_d = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q  <= RTE_RESET;
        pend_q <= 1'b0;
      end else begin
        ent_q  <= ent_d;
        pend_q <= pend_d;
      end
    end

    assign ent_arr[g]  = ent_q;
    assign pend_vec[g] = pend_q;
    assign mask_vec[g] = ent_q.mask;
    assign trig_vec[g] = ent_q.trig;
    assign rem_vec[g]  = ent_q.rem;
    assign elig[g]     = pend_q && !ent_q.mask && !(ent_q.trig && ent_q.rem);
  end

  irq_msg_port u_port (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .addr_in(msg_addr_of(ent_arr[launch_idx])),
    .data_in(msg_data_of(ent_arr[launch_idx])),
    .ready(msg_ready), .valid(msg_valid), .addr(msg_addr), .data(msg_data),
    .free(port_free));

  always_comb begin
    tbl_rdata = '0;
    if (int'(tbl_idx) < NPINS)
      tbl_rdata = tbl_half ? rte_hi(ent_arr[tbl_idx]) : rte_lo(ent_arr[tbl_idx]);
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NPINS = 24,
  parameter int IDX_W = 5,
  parameter int SRC   = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [31:0]      msg_addr,
  input logic [31:0]      msg_data,
  input logic             launch,
  input logic [IDX_W-1:0] launch_idx,
  input logic             tbl_we,
  input logic [NPINS-1:0] elig,
  input logic [NPINS-1:0] pend_vec,
  input logic [NPINS-1:0] mask_vec,
  input logic [NPINS-1:0] trig_vec,
  input logic [NPINS-1:0] rem_vec
);
  function automatic logic [NPINS-1:0] below(input logic [IDX_W-1:0] k);
    logic [NPINS-1:0] m;
    for (int i = 0; i < NPINS; i++) m[i] = (i < int'(k));
    return m;
  endfunction

  // R1: no lower-indexed pin was eligible when a pin launched
  assert_lowest_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> ((elig & below(launch_idx)) == '0));

  // R3: a level launch leaves the lockout set
  assert_lockout_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && trig_vec[launch_idx] && !tbl_we) |=> rem_vec[$past(launch_idx)]);

  // R4, R5: masked or locked-out pins never launch
  assert_no_masked_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (!mask_vec[launch_idx] && !(trig_vec[launch_idx] && rem_vec[launch_idx])));

  // R6: folded source line never requests
  assert_src_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_vec[SRC]);

  // R7: message held while stalled
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
endmodule

bind irq_route_engine irq_route_chk #(.NPINS(NPINS), .IDX_W(IDX_W), .SRC(REMAP_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .launch(launch), .launch_idx(launch_idx),
  .tbl_we(tbl_we), .elig(elig), .pend_vec(pend_vec), .mask_vec(mask_vec),
  .trig_vec(trig_vec), .rem_vec(rem_vec));

// File: tb/irq_route_engine_tb.sv
module irq_route_engine_tb;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic        tbl_we = 1'b0;
  logic [4:0]  tbl_idx = '0;
  logic        tbl_half = 1'b0;
  logic [31:0] tbl_wdata = '0;
  logic [31:0] tbl_rdata;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [31:0] msg_addr, msg_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_route_engine u_dut (.*);

  function automatic logic [31:0] lo_w(input int vec, input int dlv, input int dm,
                                      input int trig, input int mask);
    return 32'(vec % 256) + 32'(dlv % 8) * 256 + 32'(dm % 2) * 2048
         + 32'(trig % 2) * 32768 + 32'(mask % 2) * 65536;
  endfunction
  function automatic logic [31:0] ex_addr(input int dest, input int dm);
    return 32'hFEE0_0000 | (32'(dest % 65536) * 4096) | (32'(dm % 2) * 4);
  endfunction
  function automatic logic [31:0] ex_data(input int vec, input int dlv, input int trig);
    return 32'(vec % 256) + 32'(dlv % 8) * 256 + 32'(trig % 2) * 32768;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit half, input logic [31:0] d);
    tbl_idx = 5'(idx); tbl_half = half; tbl_wdata = d; tbl_we = 1'b1;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic rd(input int idx, input bit half, output logic [31:0] d);
    tbl_idx = 5'(idx); tbl_half = half;
    #1 d = tbl_rdata;
  endtask

  task automatic pulse(input int idx);
    pin_in[idx] = 1'b1;
    @(negedge clk);
    pin_in[idx] = 1'b0;
    @(negedge clk);
  endtask

  task automatic get_msg(input string tag, input logic [31:0] ea, input logic [31:0] ed);
    for (int k = 0; k < 20 && !msg_valid; k++) @(negedge clk);
    chk({tag, " valid"}, 32'(msg_valid), 32'd1);
    chk({tag, " addr"}, msg_addr, ea);
    chk({tag, " data"}, msg_data, ed);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic quiet(input string tag, input int n);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      if (msg_valid) seen = 1;
      @(negedge clk);
    end
    chk({tag, " no message"}, 32'(seen), 32'd0);
  endtask

  task automatic eoi(input int v);
    eoi_vector = 8'(v); eoi_valid = 1'b1;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, sa, sd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    chk("R12 msg_valid", 32'(msg_valid), 0);
    for (int i = 0; i < N; i++) begin
      rd(i, 0, r); chk($sformatf("R12 lo %0d", i), r, 32'h0001_0000);
      rd(i, 1, r); chk($sformatf("R12 hi %0d", i), r, 32'h0);
    end

    // R10: table read/write sweep, lockout and unused bits read 0
    for (int i = 0; i < N; i++) begin
      logic [31:0] w;
      w = lo_w(i * 7 + 3, i, i / 2, i, 1) | 32'h0000_7000 | 32'hFFFE_0000;
      wr(i, 0, w);
      wr(i, 1, {16'(i * 16'h0503 + 1), 16'hFFFF});
      rd(i, 0, r); chk($sformatf("R10 lo %0d", i), r, w & 32'h0001_8FFF);
      rd(i, 1, r); chk($sformatf("R10 hi %0d", i), r, {16'(i * 16'h0503 + 1), 16'h0});
    end
    quiet("R10 masked after writes", 4);

    // R2, R9: edge delivery sweep over pins 1..23
    for (int i = 1; i < N; i++) begin
      int dest;
      dest = (i * 257) % 65536;
      wr(i, 1, {16'(dest), 16'h0});
      wr(i, 0, lo_w(32 + i, i, i, 0, 0));
      pulse(i);
      get_msg($sformatf("R9 R2 pin %0d", i), ex_addr(dest, i), ex_data(32 + i, i, 0));
      quiet($sformatf("R2 single pin %0d", i), 3);
    end

    // R1, R7: simultaneous edges on 3, 9, 20 with stalled bus
    pin_in[3] = 1; pin_in[9] = 1; pin_in[20] = 1;
    @(negedge clk);
    pin_in = '0;
    for (int k = 0; k < 20 && !msg_valid; k++) @(negedge clk);
    sa = msg_addr; sd = msg_data;
    chk("R1 first is pin 3", msg_data, ex_data(35, 3, 0));
    repeat (3) @(negedge clk);
    chk("R7 valid held", 32'(msg_valid), 1);
    chk("R7 addr stable", msg_addr, sa);
    chk("R7 data stable", msg_data, sd);
    get_msg("R1 pin 3", ex_addr(3 * 257, 3), ex_data(35, 3, 0));
    get_msg("R1 pin 9", ex_addr(9 * 257, 9), ex_data(41, 9, 0));
    get_msg("R1 pin 20", ex_addr(20 * 257, 20), ex_data(52, 20, 0));
    quiet("R1 nothing after", 4);

    // R4: masked edge discarded
    wr(6, 0, lo_w(8'h36, 0, 0, 0, 1));
    pulse(6);
    quiet("R4 masked edge", 3);
    wr(6, 0, lo_w(8'h36, 0, 0, 0, 0));
    quiet("R4 after unmask", 5);

    // R3, R8: level lockout and end-of-interrupt
    wr(7, 1, 32'h1234_0000);
    wr(7, 0, lo_w(8'h47, 1, 0, 1, 0));
    pin_in[7] = 1'b1;
    get_msg("R3 level first", ex_addr(16'h1234, 0), ex_data(8'h47, 1, 1));
    quiet("R3 lockout", 6);
    rd(7, 0, r); chk("R3 lockout bit", r, lo_w(8'h47, 1, 0, 1, 0) | 32'h4000);
    eoi(8'h48);
    quiet("R8 wrong vector", 5);
    eoi(8'h47);
    get_msg("R8 redelivery", ex_addr(16'h1234, 0), ex_data(8'h47, 1, 1));
    pin_in[7] = 1'b0;
    @(negedge clk);
    eoi(8'h47);
    quiet("R5 deasserted level", 5);
    rd(7, 0, r); chk("R8 lockout cleared", r, lo_w(8'h47, 1, 0, 1, 0));

    // R5: masked level retained then delivered
    wr(8, 1, 32'h00AA_0000);
    wr(8, 0, lo_w(8'h58, 2, 1, 1, 1));
    pin_in[8] = 1'b1;
    quiet("R5 masked level", 5);
    wr(8, 0, lo_w(8'h58, 2, 1, 1, 0));
    get_msg("R5 unmasked level", ex_addr(16'h00AA, 1), ex_data(8'h58, 2, 1));
    pin_in[8] = 1'b0;
    @(negedge clk);
    eoi(8'h58);

    // R11: switching to edge clears lockout
    wr(10, 0, lo_w(8'h6A, 0, 0, 1, 0));
    pin_in[10] = 1'b1;
    get_msg("R11 level", ex_addr(10 * 257, 10), ex_data(8'h6A, 0, 1));
    rd(10, 0, r); chk("R11 lockout set", r, lo_w(8'h6A, 0, 0, 1, 0) | 32'h4000);
    wr(10, 0, lo_w(8'h6A, 0, 0, 0, 1));
    rd(10, 0, r); chk("R11 lockout cleared", r, lo_w(8'h6A, 0, 0, 0, 1));
    pin_in[10] = 1'b0;
    quiet("R11 masked edge", 3);

    // R6: line 0 folded onto pin 2
    wr(0, 0, lo_w(8'h10, 0, 0, 0, 0));
    wr(2, 1, 32'h0077_0000);
    wr(2, 0, lo_w(8'h12, 5, 1, 0, 0));
    pulse(0);
    get_msg("R6 fold", ex_addr(16'h0077, 1), ex_data(8'h12, 5, 0));
    quiet("R6 pin 0 silent", 4);

    // R10: out-of-range index
    wr(25, 0, 32'h0000_00FF);
    rd(25, 0, r); chk("R10 oor read", r, 32'h0);
    rd(24, 1, r); chk("R10 oor hi", r, 32'h0);
    rd(1, 0, r);  chk("R10 oor no alias", r, lo_w(33, 1, 1, 0, 0));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule